// File: doc/BRIEF.md
# Fractional-Fill Message FIFO

This block buffers received CAN messages between the frame receiver and software. Each slot holds one opaque message word. The receiver side pushes messages through a valid/ready port. Software drains the buffer through a second valid/ready port. The usable depth is chosen at run time from a small set of sizes. Software is expected to change the depth only while the buffer is empty.

A receive interrupt request is raised when the buffer has filled to a chosen fraction of its depth. The fraction is selected in eighths, or as completely full. A sticky flag records that the level was reached on a store, and software clears it with a write-one-to-clear pulse. The flag is gated by an enable bit to drive the request output.

Some settings cannot be used together. On a 4-message buffer, an odd eighth does not map to a whole number of messages. That combination, and an unused depth code, raise a configuration error. A write that arrives while the buffer is full is lost and leaves a sticky overflow flag.

Back-pressure rules on the write side: `in_ready` is high whenever the depth code is legal. It does not fall when the buffer is full, because a bus receiver cannot stall. A handshake made while full is consumed and discarded unless a read completes in the same cycle. Back-pressure rules on the read side: `out_valid` is high while at least one message is held. `out_data` stays stable until `out_ready` is seen high.

Top module: `msg_fifo_frac_irq`

## Requirements
- R1: The depth code maps 3'b001 to 4 messages, 3'b010 to 8, 3'b011 to 16, 3'b100 to 32, 3'b101 to 48 and 3'b110 to 64. For codes 3'b000 and 3'b111, `cfg_err` is high and `in_ready` is low.
- R2: Messages leave in the order they were stored. `out_valid` is high when the buffer is not empty, and a message is removed on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_data` holds its value.
- R3: `full` is high exactly when the occupancy equals the configured depth, and `empty` is high exactly when the occupancy is zero.
- R4: A write handshake while full, with no read in the same cycle, is discarded and leaves the stored contents unchanged. It sets `ovf_flag`, which holds until an `ovf_clr` pulse.
- R5: The threshold select value s (0 to 7) gives a trigger level of (s+1)*depth/8 messages. s=0 is one eighth and s=7 is completely full.
- R6: `irq_flag` sets on the clock edge where a stored message leaves the occupancy equal to the trigger level. Reads never set it, and stores that move the occupancy past the level do not set it.
- R7: `irq_flag` holds until an `irq_clr` pulse. If a setting store and a clear happen in the same cycle, the flag ends set.
- R8: `irq` is high exactly when `irq_flag` and `irq_en` are both high.
- R9: With depth code 3'b001, the odd-eighth threshold values s=0, 2, 4 and 6 raise `cfg_err`, and `irq_flag` never sets under them.
- R10: After reset the buffer is empty, `out_valid` is low, and both sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 3 | Depth code |
| thr_sel | input | 3 | Trigger level in eighths minus one |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq_flag |
| ovf_clr | input | 1 | Write-one-to-clear pulse for ovf_flag |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Write accepted (depth code legal) |
| in_data | input | WORD_W | Message word to store |
| out_valid | output | 1 | Oldest message available |
| out_ready | input | 1 | Software takes the message |
| out_data | output | WORD_W | Oldest message |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| irq_flag | output | 1 | Sticky trigger-level flag |
| irq | output | 1 | Gated interrupt request |
| ovf_flag | output | 1 | Sticky overflow flag |
| cfg_err | output | 1 | Illegal depth or depth/threshold pair |

## Verification
The occupancy counter and the two pointers cannot be seen directly. An error in any of them shows up at the ports within one cycle: `full` or `empty` would move on the wrong push, or the drained sequence would repeat, skip or reorder words. A miscomputed trigger level shows up as `irq_flag` rising one push early or late. For each depth and threshold tested, the bench checks the flag on the push just before the level and on the push that reaches it. A wrong wrap point for the 48-message depth corrupts the order in which data is drained, and the bench detects that when it drains the buffer.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int SEL_W = 3;

  // Message count for each depth code; zero marks an unused code.
  function automatic int depth_of(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      3'd5:    return 48;
      3'd6:    return 64;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/msgq_cfg_decode.sv
module msgq_cfg_decode
  import msgq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [SEL_W-1:0] depth_sel,
  input  logic [SEL_W-1:0] thr_sel,
  output logic [CNT_W-1:0] depth,
  output logic [CNT_W-1:0] thr_cnt,
  output logic             depth_ok,
  output logic             cfg_err
);
  int d_msgs;
  int t_msgs;
  logic odd_on_small;

  always_comb begin
    d_msgs       = depth_of(depth_sel);
    t_msgs       = ((int'(thr_sel) + 1) * d_msgs) / 8;
    depth        = CNT_W'(d_msgs);
    thr_cnt      = CNT_W'(t_msgs);
    depth_ok     = (d_msgs != 0);
    // value 0,2,4,6 are odd eighths; a 4-slot buffer cannot honour them
    odd_on_small = (d_msgs == 4) && !thr_sel[0];
    cfg_err      = !depth_ok || odd_on_small;
  end
endmodule

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int WORD_W    = 32,
  parameter int MAX_DEPTH = 64,
  parameter int CNT_W     = 7,
  localparam int PTR_W    = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  depth,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] slots [MAX_DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  last_idx;

  assign last_idx = PTR_W'(depth - 1'b1);
  assign rd_data  = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= step(wr_ptr, last_idx);
      if (rd_en) rd_ptr <= step(rd_ptr, last_idx);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msgq_sticky.sv
module msgq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates clear
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/msg_fifo_frac_irq.sv
module msg_fifo_frac_irq
  import msgq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_DEPTH = 64,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        depth_sel,
  input  logic [2:0]        thr_sel,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              irq_flag,
  output logic              irq,
  output logic              ovf_flag,
  output logic              cfg_err
);
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] thr_cnt;
  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   next_cnt;
  logic             depth_ok;
  logic             accept;
  logic             wr_en;
  logic             rd_en;
  logic             irq_set;
  logic             ovf_set;

  msgq_cfg_decode #(.CNT_W(CNT_W)) u_cfg (
    .depth_sel (depth_sel),
    .thr_sel   (thr_sel),
    .depth     (depth),
    .thr_cnt   (thr_cnt),
    .depth_ok  (depth_ok),
    .cfg_err   (cfg_err)
  );

  assign in_ready  = depth_ok;
  assign accept    = in_valid && in_ready;
  assign empty     = (count == '0);
  assign full      = depth_ok && (count == depth);
  assign out_valid = !empty;
  assign rd_en     = out_valid && out_ready;
  assign wr_en     = accept && (!full || rd_en);
  assign ovf_set   = accept && full && !rd_en;

  always_comb begin
    next_cnt = {1'b0, count} + (CNT_W+1)'(wr_en) - (CNT_W+1)'(rd_en);
    irq_set  = wr_en && !cfg_err && (next_cnt == {1'b0, thr_cnt});
  end

  msgq_store #(
    .WORD_W    (WORD_W),
    .MAX_DEPTH (MAX_DEPTH),
    .CNT_W     (CNT_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .depth   (depth),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_data (out_data),
    .count   (count)
  );

  msgq_sticky u_irq_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .flag_o (irq_flag)
  );

  msgq_sticky u_ovf_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr),
    .flag_o (ovf_flag)
  );

  assign irq = irq_flag && irq_en;
endmodule

// File: rtl/msgq_checker.sv
module msgq_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        depth_sel,
  input logic              irq_clr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              full,
  input logic              empty,
  input logic              irq_flag,
  input logic              ovf_flag,
  input logic              cfg_err
);
  AST_BAD_DEPTH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_sel == 3'd0 || depth_sel == 3'd7) |-> (!in_ready && cfg_err)); // R1

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !full) |=> (out_valid && $stable(out_data))); // R2

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3

  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && in_ready && !out_ready) |=> (ovf_flag && full)); // R4

  AST_FLAG_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(in_valid && in_ready)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R7

  AST_NO_FLAG_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> !$past(cfg_err)); // R9
endmodule

bind msg_fifo_frac_irq msgq_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/msg_fifo_frac_irq_test.sv
module msg_fifo_frac_irq_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   depth_sel = 3'd2;
  logic [2:0]   thr_sel = 3'd7;
  logic         irq_en = 1'b0;
  logic         irq_clr = 1'b0;
  logic         ovf_clr = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         full, empty, irq_flag, irq, ovf_flag, cfg_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  msg_fifo_frac_irq #(.WORD_W(W)) uut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] d, input logic [2:0] t);
    @(negedge clk);
    depth_sel = d;
    thr_sel   = t;
  endtask

  // drain and check sequential content starting at base
  task automatic drain_check(input string req, input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      chk(req, out_data, base + W'(i));
      pop();
    end
    chk(req, empty, 1);
  endtask

  task automatic t_reset();
    chk("R10 empty", empty, 1);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 irq_flag", irq_flag, 0);
    chk("R10 ovf_flag", ovf_flag, 0);
    chk("R3 full", full, 0);
  endtask

  task automatic t_order();
    set_cfg(3'd2, 3'd7);
    push(32'hA1); push(32'hB2); push(32'hC3);
    chk("R2 valid", out_valid, 1);
    chk("R2 head", out_data, 32'hA1);
    pop();
    chk("R2 second", out_data, 32'hB2);
    pop();
    chk("R2 third", out_data, 32'hC3);
    pop();
    chk("R3 empty", empty, 1);
    chk("R2 valid low", out_valid, 0);
  endtask

  task automatic t_threshold(input logic [2:0] dc, input int depth, input logic [2:0] s);
    int thr;
    thr = ((int'(s) + 1) * depth) / 8;
    set_cfg(dc, s);
    pulse_irq_clr();
    chk("R9 cfg_err clear", cfg_err, 0);
    for (int i = 0; i < thr - 1; i++) push(W'(1000 + i));
    chk("R5 below level", irq_flag, 0);
    push(W'(1000 + thr - 1));
    chk("R5 R6 at level", irq_flag, 1);
    @(negedge clk); irq_en = 1'b1; #1;
    chk("R8 enabled", irq, 1);
    irq_en = 1'b0; #1;
    chk("R8 disabled", irq, 0);
    if (thr < depth) begin
      push(W'(1000 + thr));
      chk("R7 still set", irq_flag, 1);
      pulse_irq_clr();
      chk("R7 cleared", irq_flag, 0);
      drain_check("R2 drain", thr + 1, 1000);
    end else begin
      chk("R3 full at depth", full, 1);
      pulse_irq_clr();
      chk("R7 cleared", irq_flag, 0);
      drain_check("R2 drain", thr, 1000);
    end
    chk("R6 no set by reads", irq_flag, 0);
  endtask

  task automatic t_depth(input logic [2:0] dc, input int depth);
    set_cfg(dc, 3'd7);
    for (int i = 0; i < depth - 1; i++) push(W'(i));
    chk("R1 R3 not full one short", full, 0);
    push(W'(depth - 1));
    chk("R1 R3 full at depth", full, 1);
    pulse_irq_clr();
    drain_check("R1 content", depth, 0);
  endtask

  task automatic t_overflow();
    set_cfg(3'd1, 3'd7);
    for (int i = 0; i < 4; i++) push(W'(50 + i));
    chk("R3 full", full, 1);
    chk("R4 ready while full", in_ready, 1);
    push(32'hDEAD);
    chk("R4 ovf set", ovf_flag, 1);
    chk("R4 still full", full, 1);
    pulse_irq_clr();
    drain_check("R4 content intact", 4, 50);
    chk("R4 ovf sticky", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R4 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_odd_on_small(input logic [2:0] s);
    set_cfg(3'd1, s);
    #1;
    chk("R9 cfg_err", cfg_err, 1);
    for (int i = 0; i < 4; i++) push(W'(i));
    chk("R9 no flag", irq_flag, 0);
    drain_check("R9 drain", 4, 0);
  endtask

  task automatic t_bad_depth();
    set_cfg(3'd0, 3'd1);
    #1;
    chk("R1 code0 err", cfg_err, 1);
    chk("R1 code0 not ready", in_ready, 0);
    push(32'h77);
    chk("R1 nothing stored", empty, 1);
    set_cfg(3'd7, 3'd1);
    #1;
    chk("R1 code7 not ready", in_ready, 0);
  endtask

  task automatic t_set_beats_clear();
    set_cfg(3'd2, 3'd1);
    pulse_irq_clr();
    push(32'h1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h2; irq_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; irq_clr = 1'b0;
    chk("R7 set beats clear", irq_flag, 1);
    pulse_irq_clr();
    drain_check("R2 drain", 2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_threshold(3'd2, 8, 3'd2);
    t_threshold(3'd5, 48, 3'd4);
    t_threshold(3'd6, 64, 3'd7);
    t_threshold(3'd1, 4, 3'd3);
    t_threshold(3'd3, 16, 3'd0);
    t_depth(3'd3, 16);
    t_depth(3'd4, 32);
    t_depth(3'd5, 48);
    t_overflow();
    t_odd_on_small(3'd0);
    t_odd_on_small(3'd2);
    t_odd_on_small(3'd6);
    t_bad_depth();
    t_set_beats_clear();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule